// File: doc/BRIEF.md
# Packet Interrupt Coalescing Unit

This unit sits beside a packet DMA channel and cuts the number of interrupts the processor has to take. It keeps a count of packets that the channel has finished but software has not yet handled. Each one-cycle completion pulse raises the count by one. Software lowers it by one for each packet it services, by writing the value 1 to the count register. An interrupt is raised once the count reaches a programmable threshold.

A small number of finished packets could otherwise wait forever below the threshold. A backup idle timer covers that case. It counts millisecond ticks while no interrupt is pending and the count is non-zero. When the programmed bound elapses with no new completion, it raises the interrupt. The interrupt stays up until software clears it through a write-one-to-clear status bit.

Register map, selected by `regAddr`. Reads are combinational and writes take effect at the next clock edge:
- 0: unserviced count.
- 1: threshold, 8 bits.
- 2: wait bound, 10 bits.
- 3: status; bit 0 is the pending flag.

Top module: `pkt_coalesce`

## Requirements
- R1: Each `pktDone` pulse adds one to the count, which reads back at address 0. The count saturates at 1023 (CNT_W=10) and does not wrap.
- R2: A write of exactly 1 to address 0 lowers the count by one. A write of any other value to address 0 leaves it unchanged. A decrement while the count is 0 is ignored, so the count stays 0.
- R3: A `pktDone` pulse and a decrement write in the same cycle both take effect, so the count keeps its value.
- R4: With a non-zero threshold, the pending flag (`irqOut`) is set on the clock edge after the count is greater than or equal to the threshold. A threshold of 0 never raises it.
- R5: The threshold register at address 1 keeps only write-data bits 7:0. For example, writing 0x1FF reads back 0xFF.
- R6: The wait bound at address 2 keeps only write-data bits 9:0, so writing 0x7FF reads back 0x3FF. A bound of 0 disables the idle timer.
- R7: While nothing is pending, the count is non-zero and the bound B is non-zero, the B-th `msTick` after the last reload sets the pending flag. The timer reloads on every `pktDone` pulse and while the flag is pending. A tick in the same cycle as `pktDone` is not counted.
- R8: While the count is 0, ticks never raise the pending flag, and the timer is held cleared.
- R9: `irqOut` stays high until a write to address 3 with data bit 0 set. A write there with bit 0 clear has no effect. If the threshold condition still holds, the flag sets again on the next edge; a set condition wins over a clear in the same cycle.
- R10: After reset the count, threshold, bound and pending flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pktDone | input | 1 | One-cycle pulse per completed packet |
| msTick | input | 1 | One-cycle pulse per elapsed millisecond |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 count, 1 threshold, 2 bound, 3 status) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr`, zero-extended |
| irqOut | output | 1 | Interrupt request (pending flag) |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is the hardware increment and the software decrement of the count. The bench drives a completion pulse in the same cycle as a decrement write. It expects the count read back in the next cycle to be unchanged, including at a count of zero.

The second pair is the threshold set and the write-one-to-clear of the pending flag. The bench clears the flag while the count is still at or above the threshold. It expects the flag to be high again on the following cycle.

A behavioural reference model is compared with `irqOut` and the read data on every clock.

// File: rtl/pkt_coalesce_pkg.sv
package pkt_coalesce_pkg;

  // register address width and map
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_THRESH = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_BOUND  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic cntUp;
    logic cntDown;
    logic thrLoad;
    logic boundLoad;
    logic waitClear;
    logic waitStep;
  } dpCtrl_t;

endpackage

// File: rtl/pkt_coalesce_dp.sv
module pkt_coalesce_dp
  import pkt_coalesce_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int THR_W   = 8,
  parameter int BOUND_W = 10,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtrl_t            ctl,
  input  logic [THR_W-1:0]   thrIn,
  input  logic [BOUND_W-1:0] boundIn,
  input  logic [ADDR_W-1:0]  rdAddr,
  input  logic               pend,
  output logic               cntZero,
  output logic               cntFull,
  output logic               thrHit,
  output logic               boundOff,
  output logic               waitDue,
  output logic [CNT_W-1:0]   countQ,
  output logic [THR_W-1:0]   thrQ,
  output logic [BOUND_W-1:0] boundQ,
  output logic [DATA_W-1:0]  rdData
);

  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0]   count;
  logic [THR_W-1:0]   thr;
  logic [BOUND_W-1:0] bound;
  logic [BOUND_W-1:0] waitCnt;
  logic [CMP_W-1:0]   cntExt;
  logic [CMP_W-1:0]   thrExt;
  logic [BOUND_W:0]   waitInc;

  // unserviced packet counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (ctl.cntUp) begin
      count <= count + 1'b1;
    end else if (ctl.cntDown) begin
      count <= count - 1'b1;
    end
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      thr   <= '0;
      bound <= '0;
    end else begin
      if (ctl.thrLoad)   thr   <= thrIn;
      if (ctl.boundLoad) bound <= boundIn;
    end
  end

  // idle timer: counts ticks since the last reload
  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (ctl.waitClear) begin
      waitCnt <= '0;
    end else if (ctl.waitStep) begin
      waitCnt <= waitCnt + 1'b1;
    end
  end

  assign cntExt   = CMP_W'(count);
  assign thrExt   = CMP_W'(thr);
  assign waitInc  = {1'b0, waitCnt} + 1'b1;

  assign cntZero  = (count == '0);
  assign cntFull  = (count == CNT_MAX);
  assign thrHit   = (thr != '0) && (cntExt >= thrExt);
  assign boundOff = (bound == '0);
  assign waitDue  = (waitInc >= {1'b0, bound});

  assign countQ = count;
  assign thrQ   = thr;
  assign boundQ = bound;

  // read multiplexer
  always_comb begin
    unique case (rdAddr)
      ADDR_COUNT:  rdData = DATA_W'(count);
      ADDR_THRESH: rdData = DATA_W'(thr);
      ADDR_BOUND:  rdData = DATA_W'(bound);
      default:     rdData = DATA_W'(pend);
    endcase
  end

endmodule

// File: rtl/pkt_coalesce_ctrl.sv
module pkt_coalesce_ctrl
  import pkt_coalesce_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pktDone,
  input  logic              msTick,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              cntZero,
  input  logic              cntFull,
  input  logic              thrHit,
  input  logic              boundOff,
  input  logic              waitDue,
  output dpCtrl_t           ctl,
  output logic              pend
);

  localparam logic [DATA_W-1:0] DEC_CODE = DATA_W'(1);

  logic decReq;
  logic clrReq;
  logic armed;
  logic fire;
  logic pendSet;

  assign decReq = regWrEn && (regAddr == ADDR_COUNT) && (regWrData == DEC_CODE);
  assign clrReq = regWrEn && (regAddr == ADDR_STATUS) && regWrData[0];

  // timer may only advance while nothing is pending and packets wait
  assign armed = !pend && !cntZero && !boundOff;
  assign fire  = armed && msTick && !pktDone && waitDue;
  assign pendSet = thrHit || fire;

  always_comb begin
    ctl = '0;
    // simultaneous up and down cancel: neither strobe fires
    ctl.cntUp     = pktDone && !decReq && !cntFull;
    ctl.cntDown   = decReq && !pktDone && !cntZero;
    ctl.thrLoad   = regWrEn && (regAddr == ADDR_THRESH);
    ctl.boundLoad = regWrEn && (regAddr == ADDR_BOUND);
    ctl.waitClear = cntZero || pktDone || pend || boundOff || fire;
    ctl.waitStep  = armed && msTick && !pktDone;
  end

  // pending flag: set wins over write-one-to-clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend <= 1'b0;
    end else if (pendSet) begin
      pend <= 1'b1;
    end else if (clrReq) begin
      pend <= 1'b0;
    end
  end

endmodule

// File: rtl/pkt_coalesce.sv
module pkt_coalesce
  import pkt_coalesce_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int THR_W   = 8,
  parameter int BOUND_W = 10,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pktDone,
  input  logic              msTick,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);

  dpCtrl_t            ctl;
  logic               pend;
  logic               cntZero;
  logic               cntFull;
  logic               thrHit;
  logic               boundOff;
  logic               waitDue;
  logic [CNT_W-1:0]   cntVal;
  logic [THR_W-1:0]   thrVal;
  logic [BOUND_W-1:0] boundVal;

  pkt_coalesce_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .pktDone(pktDone), .msTick(msTick),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .cntZero(cntZero), .cntFull(cntFull), .thrHit(thrHit),
    .boundOff(boundOff), .waitDue(waitDue), .ctl(ctl), .pend(pend)
  );

  pkt_coalesce_dp #(
    .CNT_W(CNT_W), .THR_W(THR_W), .BOUND_W(BOUND_W), .DATA_W(DATA_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .thrIn(regWrData[THR_W-1:0]), .boundIn(regWrData[BOUND_W-1:0]),
    .rdAddr(regAddr), .pend(pend),
    .cntZero(cntZero), .cntFull(cntFull), .thrHit(thrHit),
    .boundOff(boundOff), .waitDue(waitDue),
    .countQ(cntVal), .thrQ(thrVal), .boundQ(boundVal),
    .rdData(regRdData)
  );

  assign irqOut = pend;

endmodule

// File: rtl/pkt_coalesce_chk.sv
module pkt_coalesce_chk #(
  parameter int CNT_W   = 10,
  parameter int THR_W   = 8,
  parameter int BOUND_W = 10,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               pktDone,
  input logic               regWrEn,
  input logic [1:0]         regAddr,
  input logic [DATA_W-1:0]  regWrData,
  input logic               irqOut,
  input logic [CNT_W-1:0]   count,
  input logic [THR_W-1:0]   thr,
  input logic [BOUND_W-1:0] bound
);

  logic decWr;
  logic clrWr;
  assign decWr = regWrEn && (regAddr == 2'd0) && (regWrData == DATA_W'(1));
  assign clrWr = regWrEn && (regAddr == 2'd3) && regWrData[0];

  // R3
  simul_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pktDone && decWr) |=> (count == $past(count)));

  // R2
  zero_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((count == '0) && decWr && !pktDone) |=> (count == '0));

  // R4
  thr_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((thr != '0) && (count >= CNT_W'(thr))) |=> irqOut);

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !clrWr) |=> irqOut);

  // R6
  quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((bound == '0) && (thr == '0) && !irqOut) |=> !irqOut);

endmodule

bind pkt_coalesce pkt_coalesce_chk #(
  .CNT_W(CNT_W), .THR_W(THR_W), .BOUND_W(BOUND_W), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rstN(rstN), .pktDone(pktDone), .regWrEn(regWrEn),
  .regAddr(regAddr), .regWrData(regWrData), .irqOut(irqOut),
  .count(cntVal), .thr(thrVal), .bound(boundVal)
);

// File: tb/pkt_coalesce_tb_top.sv
module pkt_coalesce_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        pktDone;
  logic        msTick;
  logic        regWrEn;
  logic [1:0]  regAddr;
  logic [31:0] regWrData;
  wire  [31:0] regRdData;
  wire         irqOut;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  pkt_coalesce dut_i (
    .clk(clk), .rstN(rstN), .pktDone(pktDone), .msTick(msTick),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model, stepped each clock
  int mCount, mThr, mBound, mWait;
  bit mPend;

  always @(posedge clk) begin
    int nCount, nThr, nBound, nWait;
    bit nPend, dec, clr, armed, fire, live;
    live = rstN;
    dec = regWrEn && regAddr == 2'd0 && regWrData == 32'd1;
    clr = regWrEn && regAddr == 2'd3 && regWrData[0];
    nCount = mCount;
    if (pktDone && !dec && mCount < 1023) nCount = mCount + 1;
    if (dec && !pktDone && mCount > 0)    nCount = mCount - 1;
    nThr   = (regWrEn && regAddr == 2'd1) ? int'(regWrData & 32'hFF)  : mThr;
    nBound = (regWrEn && regAddr == 2'd2) ? int'(regWrData & 32'h3FF) : mBound;
    armed = !mPend && mCount != 0 && mBound != 0;
    fire  = armed && msTick && !pktDone && (mWait + 1 >= mBound);
    if (mCount == 0 || pktDone || mPend || mBound == 0 || fire) nWait = 0;
    else if (armed && msTick) nWait = mWait + 1;
    else nWait = mWait;
    if ((mThr != 0 && mCount >= mThr) || fire) nPend = 1'b1;
    else if (clr) nPend = 1'b0;
    else nPend = mPend;
    #2;
    if (!live) begin
      mCount = 0; mThr = 0; mBound = 0; mWait = 0; mPend = 1'b0;
    end else begin
      mCount = nCount; mThr = nThr; mBound = nBound; mWait = nWait; mPend = nPend;
      chk("R9 model irqOut", {31'd0, irqOut}, {31'd0, mPend});
      case (regAddr)
        2'd0: chk("R1 model read", regRdData, mCount);
        2'd1: chk("R5 model read", regRdData, mThr);
        2'd2: chk("R6 model read", regRdData, mBound);
        default: chk("R9 model read", regRdData, {31'd0, mPend});
      endcase
    end
  end

  task automatic cyc(bit pd, bit tk, bit we, logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    pktDone = pd; msTick = tk; regWrEn = we; regAddr = a; regWrData = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 2'd0, 32'd0);
  endtask

  task automatic rd(logic [1:0] a, logic [31:0] exp, string tag);
    cyc(0, 0, 0, a, 32'd0);
    #1 chk(tag, regRdData, exp);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      cyc(0, 1, 0, 2'd0, 32'd0);
      cyc(0, 0, 0, 2'd0, 32'd0);
    end
  endtask

  task automatic irqIs(bit exp, string tag);
    idle(1);
    #1 chk(tag, {31'd0, irqOut}, {31'd0, exp});
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; pktDone = 0; msTick = 0; regWrEn = 0; regAddr = 0; regWrData = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10 reset state
    rd(2'd0, 32'd0, "R10 count");
    rd(2'd1, 32'd0, "R10 thresh");
    rd(2'd2, 32'd0, "R10 bound");
    rd(2'd3, 32'd0, "R10 status");
    // R5 threshold width
    cyc(0, 0, 1, 2'd1, 32'h1FF);
    rd(2'd1, 32'hFF, "R5 thresh low byte");
    cyc(0, 0, 1, 2'd1, 32'd4);
    // R1 / R4 counting to threshold
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 2'd0, 32'd0);
    rd(2'd0, 32'd3, "R1 count three");
    #1 chk("R4 below threshold", {31'd0, irqOut}, 32'd0);
    cyc(1, 0, 0, 2'd0, 32'd0);
    rd(2'd0, 32'd4, "R1 count four");
    irqIs(1'b1, "R4 threshold reached");
    // R2 decrement rules
    cyc(0, 0, 1, 2'd0, 32'd2);
    rd(2'd0, 32'd4, "R2 non-one write ignored");
    cyc(0, 0, 1, 2'd0, 32'd1);
    rd(2'd0, 32'd3, "R2 decrement");
    // R3 simultaneous
    cyc(1, 0, 1, 2'd0, 32'd1);
    rd(2'd0, 32'd3, "R3 inc and dec together");
    // R9 clearing
    cyc(0, 0, 1, 2'd3, 32'd2);
    irqIs(1'b1, "R9 bit0 clear write no effect");
    cyc(0, 0, 1, 2'd3, 32'd1);
    irqIs(1'b0, "R9 cleared");
    cyc(0, 0, 1, 2'd1, 32'd2);
    idle(2);
    cyc(0, 0, 1, 2'd3, 32'd1);
    irqIs(1'b1, "R9 reasserts while over threshold");
    cyc(0, 0, 1, 2'd1, 32'd0);
    cyc(0, 0, 1, 2'd3, 32'd1);
    irqIs(1'b0, "R4 threshold zero disables");
    // R2 floor at zero, with R3 at zero
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 2'd0, 32'd1);
    rd(2'd0, 32'd0, "R2 down to zero");
    cyc(0, 0, 1, 2'd0, 32'd1);
    rd(2'd0, 32'd0, "R2 floor at zero");
    cyc(1, 0, 1, 2'd0, 32'd1);
    rd(2'd0, 32'd0, "R3 together at zero");
    // R6 bound width
    cyc(0, 0, 1, 2'd2, 32'h7FF);
    rd(2'd2, 32'h3FF, "R6 bound ten bits");
    cyc(0, 0, 1, 2'd2, 32'd5);
    // R8 ticks with empty count
    ticks(10);
    irqIs(1'b0, "R8 no fire at zero count");
    // R7 idle timer
    cyc(1, 0, 0, 2'd0, 32'd0);
    ticks(4);
    irqIs(1'b0, "R7 before bound");
    cyc(1, 1, 0, 2'd0, 32'd0);
    ticks(4);
    irqIs(1'b0, "R7 reload on packet");
    ticks(1);
    irqIs(1'b1, "R7 fires at bound");
    // R6 bound zero disables
    cyc(0, 0, 1, 2'd2, 32'd0);
    cyc(0, 0, 1, 2'd3, 32'd1);
    ticks(20);
    irqIs(1'b0, "R6 timer disabled");
    // R1 saturation
    for (int i = 0; i < 1030; i++) cyc(1, 0, 0, 2'd0, 32'd0);
    rd(2'd0, 32'd1023, "R1 saturate");
    irqIs(1'b0, "R4 zero threshold at full count");
    idle(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule